// File: doc/BRIEF.md
# Block Floating Point Shift Tracker

This block implements a two-pass block exponent scheme around an external leading-digit encoder. Each cycle it may accept one vector element together with that element's normalization distance, the number of left-shift places the encoder reports for it. While one vector streams through, a comparator and a holding register track the largest distance seen since the block started. At the block's final element that largest distance is committed to an apply register.

The apply register sets the shift for every element that follows. Each element is shifted left by the committed distance, and the vacated low bits are filled with zeros. One pass therefore measures the distance for the next block while the distance measured in the previous pass is applied to the current data, both in the same pipeline. The element-by-element normalizer is never used. The block computes no exponent arithmetic outside this tracking and shifting.

Top module: `bfp_block_shift`

## Requirements
- R1: While rst_n is low at a clock edge, every output is cleared after that edge: out_valid = 0, out_data = 0, block_shift = 0.
- R2: out_valid equals in_valid delayed by one clock. When out_valid is 1, out_data is the element accepted one cycle earlier, shifted left by the block_shift value that was in force in that cycle. Zeros enter at bit 0, and bits moved past the top bit are lost.
- R3: When an element is accepted with in_eob = 1, block_shift takes, from the next cycle on, the largest in_shift among the block's accepted elements. The block runs from its in_sob element, or from the element after the previous in_eob, through the in_eob element itself.
- R4: An accepted element carrying in_sob = 1 discards everything tracked so far. The running maximum restarts from that element's own shift.
- R5: The element carrying in_eob is still shifted by the old block_shift. The first element accepted after it uses the new value.
- R6: After an in_eob the running maximum returns to zero. A block whose first element has no in_sob is therefore measured from zero.
- R7: A cycle with in_valid = 0 is ignored: in_shift, in_sob and in_eob have no effect, and out_valid is 0 in the next cycle.
- R8: Until the first block completes, block_shift is 0, so elements pass unshifted. block_shift changes only after an accepted in_eob.
- R9: An element carrying both in_sob and in_eob forms a one-element block, and block_shift becomes that element's in_shift.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Element present this cycle |
| in_data | input | DATA_W (32) | Element value |
| in_shift | input | SHIFT_W (5) | Element's normalization distance from the encoder |
| in_sob | input | 1 | First element of a block |
| in_eob | input | 1 | Last element of a block |
| out_valid | output | 1 | out_data holds a shifted element |
| out_data | output | DATA_W (32) | Element shifted by the committed distance |
| block_shift | output | SHIFT_W (5) | Committed distance currently applied |

## Verification
A shifted element appears on out_data with out_valid one clock after it is accepted. A committed distance shows on block_shift one clock after the accepted in_eob edge, and it first applies to the element accepted in that cycle. The driver records each expected element just after the edge that accepts it, and it updates its model of the committed distance at the same moment. The monitor compares outputs at the following falling edge, so every expected value lines up with the register stage that produces it. Directed blocks cover the restart, coincident and zero-start cases, and a long random run mixes strobes and idle cycles.

// File: rtl/bfp_pkg.sv
// Package: shared helpers for the block floating point shift tracker.
// Assumes shift distances are unsigned.
package bfp_pkg;

    // Returns the larger of two unsigned distances of width 8 or less.
    function automatic logic [7:0] umax8(input logic [7:0] a, input logic [7:0] b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/bfp_left_shifter.sv
// Module: bfp_left_shifter
// Purely combinational logarithmic left shifter with zero fill.
// Assumes amt is unsigned. Stages whose step reaches DATA_W clear the word.
module bfp_left_shifter #(
    parameter int DATA_W  = 32,
    parameter int SHIFT_W = 5
) (
    input  logic [DATA_W-1:0]  din,
    input  logic [SHIFT_W-1:0] amt,
    output logic [DATA_W-1:0]  dout
);
    logic [DATA_W-1:0] stage [0:SHIFT_W];

    assign stage[0] = din;

    for (genvar k = 0; k < SHIFT_W; k++) begin : g_stage
        localparam int STEP = 1 << k;
        if (STEP < DATA_W) begin : g_move
            // Shift by STEP places when this bit of the amount is set.
            assign stage[k+1] = amt[k] ? {stage[k][DATA_W-STEP-1:0], {STEP{1'b0}}}
                                       : stage[k];
        end else begin : g_clear
            // A step as wide as the word empties it.
            assign stage[k+1] = amt[k] ? '0 : stage[k];
        end
    end

    assign dout = stage[SHIFT_W];
endmodule

// File: rtl/bfp_shift_tracker.sv
// Module: bfp_shift_tracker
// Keeps the running maximum of the element shift distances and commits it
// to the apply register at the end of each block.
// Assumes strobes count only on cycles with in_valid high.
module bfp_shift_tracker #(
    parameter int SHIFT_W = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic [SHIFT_W-1:0] in_shift,
    input  logic               in_sob,
    input  logic               in_eob,
    output logic [SHIFT_W-1:0] run_max,
    output logic [SHIFT_W-1:0] applied
);
    import bfp_pkg::*;

    logic [SHIFT_W-1:0] base;
    logic [SHIFT_W-1:0] cand;

    // Start of block ignores the stale running value.
    always_comb begin
        base = in_sob ? '0 : run_max;
        cand = SHIFT_W'(umax8(8'(base), 8'(in_shift)));
    end

    // Update the running maximum, and commit it on the final element of a block.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_max <= '0;
            applied <= '0;
        end else if (in_valid) begin
            if (in_eob) begin
                applied <= cand;
                run_max <= '0;
            end else begin
                run_max <= cand;
            end
        end
    end
endmodule

// File: rtl/bfp_block_shift.sv
// Module: bfp_block_shift (top)
// Two-pass block floating point shifter. It measures the next block's
// distance while it applies the previous block's distance. Latency is one cycle.
// Assumes in_shift comes from an external leading-digit encoder.
module bfp_block_shift #(
    parameter int DATA_W  = 32,
    parameter int SHIFT_W = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic [DATA_W-1:0]  in_data,
    input  logic [SHIFT_W-1:0] in_shift,
    input  logic               in_sob,
    input  logic               in_eob,
    output logic               out_valid,
    output logic [DATA_W-1:0]  out_data,
    output logic [SHIFT_W-1:0] block_shift
);
    logic [SHIFT_W-1:0] trk_max;
    logic [SHIFT_W-1:0] apply_q;
    logic [DATA_W-1:0]  shifted;

    bfp_shift_tracker #(.SHIFT_W(SHIFT_W)) u_trk (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .in_shift (in_shift),
        .in_sob   (in_sob),
        .in_eob   (in_eob),
        .run_max  (trk_max),
        .applied  (apply_q)
    );

    bfp_left_shifter #(.DATA_W(DATA_W), .SHIFT_W(SHIFT_W)) u_shf (
        .din  (in_data),
        .amt  (apply_q),
        .dout (shifted)
    );

    // Register the shifted element together with its valid flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) out_data <= shifted;
        end
    end

    assign block_shift = apply_q;
endmodule

// File: rtl/bfp_block_shift_chk.sv
// Module: bfp_block_shift_chk
// Protocol and timing checks, bound into bfp_block_shift.
module bfp_block_shift_chk #(
    parameter int DATA_W  = 32,
    parameter int SHIFT_W = 5
) (
    input logic               clk,
    input logic               rst_n,
    input logic               in_valid,
    input logic [SHIFT_W-1:0] in_shift,
    input logic               in_sob,
    input logic               in_eob,
    input logic               out_valid,
    input logic [DATA_W-1:0]  out_data,
    input logic [SHIFT_W-1:0] block_shift,
    input logic [SHIFT_W-1:0] trk
);
    assert_valid_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    assert_idle_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && $stable(trk) && $stable(block_shift) && $stable(out_data)));
    assert_apply_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(in_valid && in_eob) |=> $stable(block_shift));
    assert_commit_covers_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_eob) |=> (block_shift >= $past(in_shift)));
    assert_restart_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_sob && !in_eob) |=> (trk == $past(in_shift)));
    assert_clear_after_end_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_eob) |=> (trk == '0));
    assert_single_block_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_sob && in_eob) |=> (block_shift == $past(in_shift)));
endmodule

bind bfp_block_shift bfp_block_shift_chk #(.DATA_W(DATA_W), .SHIFT_W(SHIFT_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .in_shift    (in_shift),
    .in_sob      (in_sob),
    .in_eob      (in_eob),
    .out_valid   (out_valid),
    .out_data    (out_data),
    .block_shift (block_shift),
    .trk         (trk_max)
);

// File: tb/bfp_block_shift_test.sv
module bfp_block_shift_test;
    localparam int DW = 32;
    localparam int SW = 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic [DW-1:0] in_data = '0;
    logic [SW-1:0] in_shift = '0;
    logic          in_sob = 1'b0;
    logic          in_eob = 1'b0;
    logic          out_valid;
    logic [DW-1:0] out_data;
    logic [SW-1:0] block_shift;

    int checks = 0;
    int fails  = 0;
    logic [DW-1:0] exp_q [$];
    string         tag_q [$];
    int            mdl_trk = 0;
    int            mdl_apply = 0;
    bit            mon_on = 1'b0;
    bit            done = 1'b0;

    always #4 clk = ~clk;

    bfp_block_shift #(.DATA_W(DW), .SHIFT_W(SW)) uut (.*);

    // Drive one cycle; record expectation and update the model after the edge.
    task automatic send(input bit v, input logic [DW-1:0] d, input int s,
                        input bit sob, input bit eob, input string tag);
        int base, m;
        @(negedge clk);
        in_valid = v; in_data = d; in_shift = SW'(s); in_sob = sob; in_eob = eob;
        @(posedge clk);
        #1;
        if (v) begin
            exp_q.push_back(d << mdl_apply);
            tag_q.push_back(tag);
            base = sob ? 0 : mdl_trk;
            m = (s > base) ? s : base;
            if (eob) begin mdl_apply = m; mdl_trk = 0; end
            else mdl_trk = m;
        end
    endtask

    // Monitor: compare outputs against the scoreboard at each falling edge.
    always @(negedge clk) begin
        if (mon_on) begin
            checks++;
            if (block_shift !== SW'(mdl_apply)) begin
                fails++;
                $display("FAIL R3/R5/R8 block_shift actual=%0d expected=%0d", block_shift, mdl_apply);
            end
            if (out_valid) begin
                checks++;
                if (exp_q.size() == 0) begin
                    fails++;
                    $display("FAIL R7 out_valid actual=1 expected=0");
                end else begin
                    logic [DW-1:0] e;
                    string t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    if (out_data !== e) begin
                        fails++;
                        $display("FAIL %s out_data actual=%h expected=%h", t, out_data, e);
                    end
                end
            end else if (exp_q.size() != 0) begin
                checks++;
                fails++;
                $display("FAIL R2 out_valid actual=0 expected=1");
                void'(exp_q.pop_front());
                void'(tag_q.pop_front());
            end
        end
    end

    initial begin
        #1000000;
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        checks++;
        if (out_valid !== 1'b0 || block_shift !== '0 || out_data !== '0) begin
            fails++;
            $display("FAIL R1 reset actual=%b/%0d/%h expected=0/0/0", out_valid, block_shift, out_data);
        end
        rst_n = 1'b1;
        mon_on = 1'b1;
        // R8: unshifted before any block completes
        send(1, 32'h0000_00F1, 6, 0, 0, "R8");
        send(1, 32'h8000_0001, 2, 0, 0, "R8");
        // R3: block of four, maximum 7; R5: the eob element still uses 0
        send(1, 32'h0000_0003, 3, 1, 0, "R3");
        send(1, 32'h0000_0005, 7, 0, 0, "R3");
        send(1, 32'h0000_0007, 2, 0, 0, "R3");
        send(1, 32'h0000_0009, 5, 0, 1, "R5");
        // R5: the next element uses 7
        send(1, 32'h0100_0001, 1, 1, 0, "R5");
        send(1, 32'h0000_00FF, 4, 0, 1, "R2");
        // R7: idle cycles with large shift and strobes are ignored
        send(0, 32'hFFFF_FFFF, 31, 1, 1, "R7");
        send(0, 32'hFFFF_FFFF, 31, 0, 1, "R7");
        send(1, 32'h0000_0011, 0, 0, 0, "R7");
        // R4: restart mid-block discards 20 and 25
        send(1, 32'h0000_0001, 20, 1, 0, "R4");
        send(1, 32'h0000_0001, 25, 0, 0, "R4");
        send(1, 32'h0000_0002, 2, 1, 0, "R4");
        send(1, 32'h0000_0002, 3, 0, 1, "R4");
        // R6: block without sob starts from zero
        send(1, 32'h0000_0004, 1, 0, 0, "R6");
        send(1, 32'h0000_0004, 2, 0, 1, "R6");
        // R9: single-element block
        send(1, 32'h0000_000C, 9, 1, 1, "R9");
        send(1, 32'h0000_000C, 31, 1, 1, "R9");
        // R2: shift 31 keeps only bit 0, moved to the top
        send(1, 32'hFFFF_FFFF, 0, 1, 0, "R2");
        send(1, 32'h0000_0003, 0, 0, 1, "R2");
        send(1, 32'h1234_5678, 0, 0, 0, "R2");
        // random mix
        for (int i = 0; i < 400; i++) begin
            bit v;
            v = ($urandom_range(0, 3) != 0);
            send(v, DW'($urandom), int'($urandom_range(0, 31)),
                 ($urandom_range(0, 5) == 0), ($urandom_range(0, 4) == 0), "R3");
        end
        send(0, '0, 0, 0, 0, "R7");
        send(0, '0, 0, 0, 0, "R7");
        mon_on = 1'b0;
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule